// File: doc/BRIEF.md
# Serial Channel Interrupt Aggregator

This block merges the interrupt causes of sixteen serial channels into one request line. Each channel keeps a 32-bit status word. Receive-data, overrun, transmit-empty and modem-line-change causes are held in it as sticky flags. Alongside them, the synchronized levels of the four modem inputs appear as plain mirror bits. A channel control word selects which cause classes may raise the channel's request. The channel requests form a raw vector. That vector is filtered by an active-high disable mask, and the result passes two enables, one for the aggregator and one for the card, before it reaches the registered interrupt output.

Software reaches every register through a simple word-addressed bus. It reads a channel's status word and writes the same value back to acknowledge exactly the causes it has seen. The level bits are unaffected by that write. Channel event pulses and modem levels arrive as plain inputs from the serial engines. The modem levels may be asynchronous and are synchronized inside the block.

Top module: `sio_irq_agg`

## Requirements
- R1: After reset the channel mask word (address 33) reads 0xFFFF, the aggregator and card words read 0, every channel control word and every sticky flag is 0, and `irq_o` is low.
- R2: A one-cycle pulse sets a sticky flag in the channel's status word, and the flag stays set until it is cleared by a write. Receive data sets bit 0, overrun sets bit 13 and transmit empty sets bit 25.
- R3: The status word mirrors the synchronized modem levels: DCD in bit 3, DSR in bit 4, CTS in bit 5 and RI in bit 6. Any rising or falling edge of a synchronized level sets that line's sticky change flag: DSR bit 16, CTS bit 17, DCD bit 18, RI bit 22.
- R4: Writing a status word (address 2·ch) clears each sticky flag written with a 1. Writing 0 to a bit, or writing any value to a level bit or an unused bit, changes nothing.
- R5: If an event arrives in the same cycle as a write that clears its flag, the flag stays set.
- R6: The channel control word (address 2·ch+1) holds three enables: bit 0 for modem changes, bit 2 for receive and overrun, and bit 19 for transmit empty. Its other bits read 0. Bit ch of the raw request word (address 32) is 1 exactly when at least one set flag of channel ch belongs to an enabled class.
- R7: The mask word (address 33) disables channel ch when bit ch is 1. The pending set is the raw request word AND NOT the mask.
- R8: `irq_o` rises only when at least one channel is pending, bit 20 of the aggregator word (address 34) is 1, and bit 0 of the card word (address 35) is 1. The aggregator word keeps only bit 20. The card word keeps all 32 written bits, but only bit 0 has an effect.
- R9: `irq_o` is registered. An event pulse sampled at clock edge N, on an enabled and unmasked channel with both enables set, raises `irq_o` at edge N+1 and not before.
- R10: Read data is registered. It reflects the address presented in the cycle before it appears. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rx_evt_i | input | 16 | Per-channel receive-data pulses |
| ovr_evt_i | input | 16 | Per-channel overrun pulses |
| tx_evt_i | input | 16 | Per-channel transmit-empty pulses |
| dcd_i | input | 16 | Per-channel DCD level, asynchronous |
| dsr_i | input | 16 | Per-channel DSR level, asynchronous |
| cts_i | input | 16 | Per-channel CTS level, asynchronous |
| ri_i | input | 16 | Per-channel RI level, asynchronous |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled on the rising clock edge. They also assume that the modem levels are low while reset is applied; otherwise the first synchronized sample after reset would count as an edge. The stimulus drives every input at the falling edge, pulses each event for exactly one cycle, and returns all modem lines low before it applies reset in the middle of the run. It then waits for the synchronizer depth plus the edge detector before it reads the status words.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int WORD_W = 32;

  // status word positions
  localparam int P_RX   = 0;
  localparam int P_LVL  = 3;   // four levels: DCD, DSR, CTS, RI from here up
  localparam int P_OVR  = 13;
  localparam int P_TX   = 25;

  // channel control enables
  localparam int C_MS   = 0;
  localparam int C_RX   = 2;
  localparam int C_TX   = 19;

  // global enables
  localparam int G_AGG  = 20;
  localparam int G_CARD = 0;

  // modem line index: 0 DCD, 1 DSR, 2 CTS, 3 RI
  localparam int N_MDM = 4;

  function automatic int chg_pos(input int k);
    case (k)
      0:       chg_pos = 18;
      1:       chg_pos = 16;
      2:       chg_pos = 17;
      default: chg_pos = 22;
    endcase
  endfunction

  localparam logic [WORD_W-1:0] CHG_MASK =
    (32'h1 << 16) | (32'h1 << 17) | (32'h1 << 18) | (32'h1 << 22);
  localparam logic [WORD_W-1:0] STICKY_MASK =
    CHG_MASK | (32'h1 << P_RX) | (32'h1 << P_OVR) | (32'h1 << P_TX);
  localparam logic [WORD_W-1:0] CTRL_MASK =
    (32'h1 << C_MS) | (32'h1 << C_RX) | (32'h1 << C_TX);
  localparam logic [WORD_W-1:0] AGG_MASK = 32'h1 << G_AGG;

endpackage

// File: rtl/sio_irq_sync.sv
module sio_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
  import sio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_evt_i,
  input  logic              ovr_evt_i,
  input  logic              tx_evt_i,
  input  logic [N_MDM-1:0]  mdm_i,
  input  logic              st_wr_i,
  input  logic              ct_wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              req_o
);

  logic [N_MDM-1:0]  lvl_s, lvl_prev_q, mdm_tgl;
  logic [WORD_W-1:0] evt_word, lvl_word, clr_word, sticky_q, ctrl_q;

  sio_irq_sync #(.WIDTH(N_MDM), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (mdm_i),
    .q_o (lvl_s)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_prev_q <= '0;
    else     lvl_prev_q <= lvl_s;
  end

  assign mdm_tgl = lvl_s ^ lvl_prev_q;

  always_comb begin
    evt_word = '0;
    lvl_word = '0;
    evt_word[P_RX]  = rx_evt_i;
    evt_word[P_OVR] = ovr_evt_i;
    evt_word[P_TX]  = tx_evt_i;
    for (int k = 0; k < N_MDM; k++) begin
      evt_word[chg_pos(k)] = mdm_tgl[k];
      lvl_word[P_LVL + k]  = lvl_s[k];
    end
  end

  assign clr_word = st_wr_i ? (wdata_i & STICKY_MASK) : '0;

  // events override a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) sticky_q <= '0;
    else     sticky_q <= ((sticky_q & ~clr_word) | evt_word) & STICKY_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ct_wr_i) ctrl_q <= wdata_i & CTRL_MASK;
  end

  logic cls_rx, cls_ms, cls_tx;
  assign cls_rx = (sticky_q[P_RX] | sticky_q[P_OVR]) & ctrl_q[C_RX];
  assign cls_ms = (|(sticky_q & CHG_MASK)) & ctrl_q[C_MS];
  assign cls_tx = sticky_q[P_TX] & ctrl_q[C_TX];

  assign req_o    = cls_rx | cls_ms | cls_tx;
  assign status_o = sticky_q | lvl_word;
  assign ctrl_o   = ctrl_q;

  // R2: a set flag that is not written survives
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !st_wr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  // R3: a toggle on a synchronized modem line leaves a change flag set
  a_r3_toggle_flags: assert property (@(posedge clk) disable iff (rst)
    (mdm_tgl != '0) |=> ((sticky_q & CHG_MASK) != '0));

  // R4: a clear without a simultaneous event removes the flag
  a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
    st_wr_i |=> ((sticky_q & $past(wdata_i & ~evt_word & STICKY_MASK)) == '0));

  // R5: an event wins over a same-cycle clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_word != '0) |=> ((sticky_q & $past(evt_word)) == $past(evt_word)));

  // R6: only the three enable bits are ever held
  a_r6_ctrl_bits: assert property (@(posedge clk) disable iff (rst)
    ct_wr_i |=> (ctrl_q == $past(wdata_i & CTRL_MASK)));

endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] raw_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           agg_en_i,
  input  logic           card_en_i,
  output logic           irq_o
);

  logic [NCH-1:0] pending;
  logic           irq_q;

  assign pending = raw_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|pending) & agg_en_i & card_en_i;
  end

  assign irq_o = irq_q;

  // R7: nothing pending keeps the line low
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |=> !irq_o);

  // R8: either enable low keeps the line low
  a_r8_two_enables: assert property (@(posedge clk) disable iff (rst)
    !(agg_en_i && card_en_i) |=> !irq_o);

  // R9: a pending channel with both enables raises the line one edge later
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ((pending != '0) && agg_en_i && card_en_i) |=> irq_o);

endmodule

// File: rtl/sio_irq_agg.sv
module sio_irq_agg
  import sio_irq_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    rx_evt_i,
  input  logic [NCH-1:0]    ovr_evt_i,
  input  logic [NCH-1:0]    tx_evt_i,
  input  logic [NCH-1:0]    dcd_i,
  input  logic [NCH-1:0]    dsr_i,
  input  logic [NCH-1:0]    cts_i,
  input  logic [NCH-1:0]    ri_i,
  output logic              irq_o
);

  localparam int CH_W    = $clog2(NCH);
  localparam int CH_SPAN = 2 * NCH;
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(CH_SPAN);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(CH_SPAN + 1);
  localparam logic [ADDR_W-1:0] A_AGG  = ADDR_W'(CH_SPAN + 2);
  localparam logic [ADDR_W-1:0] A_CARD = ADDR_W'(CH_SPAN + 3);

  logic [WORD_W-1:0] status_w [NCH];
  logic [WORD_W-1:0] ctrl_w   [NCH];
  logic [NCH-1:0]    raw, st_wr, ct_wr;
  logic [NCH-1:0]    mask_q;
  logic [WORD_W-1:0] agg_q, card_q, rd_d, rd_q;
  logic [CH_W-1:0]   rd_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign st_wr[g] = reg_we && (reg_addr == ADDR_W'(2 * g));
    assign ct_wr[g] = reg_we && (reg_addr == ADDR_W'(2 * g + 1));

    sio_irq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .rx_evt_i  (rx_evt_i[g]),
      .ovr_evt_i (ovr_evt_i[g]),
      .tx_evt_i  (tx_evt_i[g]),
      .mdm_i     ({ri_i[g], cts_i[g], dsr_i[g], dcd_i[g]}),
      .st_wr_i   (st_wr[g]),
      .ct_wr_i   (ct_wr[g]),
      .wdata_i   (reg_wdata),
      .status_o  (status_w[g]),
      .ctrl_o    (ctrl_w[g]),
      .req_o     (raw[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      agg_q  <= '0;
      card_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_MASK) mask_q <= reg_wdata[NCH-1:0];
      if (reg_addr == A_AGG)  agg_q  <= reg_wdata & AGG_MASK;
      if (reg_addr == A_CARD) card_q <= reg_wdata;
    end
  end

  sio_irq_merge #(.NCH(NCH)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .raw_i     (raw),
    .mask_i    (mask_q),
    .agg_en_i  (agg_q[G_AGG]),
    .card_en_i (card_q[G_CARD]),
    .irq_o     (irq_o)
  );

  assign rd_ch = reg_addr[CH_W:1];

  always_comb begin
    rd_d = '0;
    if (reg_addr < ADDR_W'(CH_SPAN)) begin
      rd_d = reg_addr[0] ? ctrl_w[rd_ch] : status_w[rd_ch];
    end else begin
      case (reg_addr)
        A_RAW:   rd_d[NCH-1:0] = raw;
        A_MASK:  rd_d[NCH-1:0] = mask_q;
        A_AGG:   rd_d = agg_q;
        A_CARD:  rd_d = card_q;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;

  // R1: reset leaves every channel masked and the line low
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> ((mask_q == '1) && !irq_o && (agg_q == '0) && (card_q == '0)));

  // R10: a write reaches at most one channel register
  a_r10_decode_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_wr, ct_wr}));

endmodule

// File: tb/tb_sio_irq_agg.sv
module tb_sio_irq_agg;

  localparam int NCH = 16;
  localparam int AW  = 6;
  localparam int TIMEOUT_CYC = 20000;

  localparam logic [3:0] OP_WR  = 4'd0;
  localparam logic [3:0] OP_RD  = 4'd1;
  localparam logic [3:0] OP_RX  = 4'd2;
  localparam logic [3:0] OP_OVR = 4'd3;
  localparam logic [3:0] OP_TX  = 4'd4;
  localparam logic [3:0] OP_MDM = 4'd5;
  localparam logic [3:0] OP_IRQ = 4'd6;

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  req;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 63;
  // addresses: status 2*ch, control 2*ch+1, raw 32, mask 33, agg 34, card 35
  localparam vec_t TBL [NV] = '{
    '{OP_RD , 8'd1 , 6'd33, 32'h0       , 32'h0000FFFF}, // R1 mask reset
    '{OP_RD , 8'd1 , 6'd34, 32'h0       , 32'h0       }, // R1 agg reset
    '{OP_RD , 8'd1 , 6'd0 , 32'h0       , 32'h0       }, // R1 status reset
    '{OP_IRQ, 8'd1 , 6'd0 , 32'h0       , 32'h0       }, // R1 line low
    '{OP_RX , 8'd2 , 6'd3 , 32'h0       , 32'h0       }, // R2 rx on ch3
    '{OP_RD , 8'd2 , 6'd6 , 32'h0       , 32'h00000001},
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h0       }, // R6 class off
    '{OP_WR , 8'd6 , 6'd7 , 32'h4       , 32'h0       },
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h00000008},
    '{OP_IRQ, 8'd7 , 6'd0 , 32'h0       , 32'h0       }, // R7 all masked
    '{OP_WR , 8'd7 , 6'd33, 32'hFFF7    , 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h0       }, // R8 no enables
    '{OP_WR , 8'd8 , 6'd34, 32'h00100000, 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h0       },
    '{OP_WR , 8'd8 , 6'd35, 32'h1       , 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h1       },
    '{OP_WR , 8'd8 , 6'd34, 32'h000FFFFF, 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h0       },
    '{OP_RD , 8'd8 , 6'd34, 32'h0       , 32'h0       },
    '{OP_WR , 8'd8 , 6'd34, 32'h00100000, 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h1       },
    '{OP_WR , 8'd8 , 6'd35, 32'hFFFFFFFE, 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h0       },
    '{OP_RD , 8'd8 , 6'd35, 32'h0       , 32'hFFFFFFFE},
    '{OP_WR , 8'd8 , 6'd35, 32'h1       , 32'h0       },
    '{OP_IRQ, 8'd8 , 6'd0 , 32'h0       , 32'h1       },
    '{OP_WR , 8'd4 , 6'd6 , 32'h1       , 32'h0       }, // R4 ack rx
    '{OP_RD , 8'd4 , 6'd6 , 32'h0       , 32'h0       },
    '{OP_IRQ, 8'd4 , 6'd0 , 32'h0       , 32'h0       },
    '{OP_MDM, 8'd3 , 6'd5 , 32'h4       , 32'h0       }, // R3 CTS rises ch5
    '{OP_RD , 8'd3 , 6'd10, 32'h0       , 32'h00020020},
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h0       },
    '{OP_WR , 8'd6 , 6'd11, 32'h1       , 32'h0       },
    '{OP_WR , 8'd7 , 6'd33, 32'hFFDF    , 32'h0       },
    '{OP_IRQ, 8'd7 , 6'd0 , 32'h0       , 32'h1       },
    '{OP_WR , 8'd4 , 6'd10, 32'hFFFFFFFF, 32'h0       }, // R4 level kept
    '{OP_RD , 8'd4 , 6'd10, 32'h0       , 32'h00000020},
    '{OP_IRQ, 8'd4 , 6'd0 , 32'h0       , 32'h0       },
    '{OP_MDM, 8'd3 , 6'd5 , 32'h0       , 32'h0       }, // R3 falling edge
    '{OP_RD , 8'd3 , 6'd10, 32'h0       , 32'h00020000},
    '{OP_WR , 8'd4 , 6'd10, 32'h00020000, 32'h0       },
    '{OP_MDM, 8'd3 , 6'd5 , 32'hB       , 32'h0       }, // R3 DCD DSR RI
    '{OP_RD , 8'd3 , 6'd10, 32'h0       , 32'h00450058},
    '{OP_WR , 8'd4 , 6'd10, 32'h00450058, 32'h0       },
    '{OP_RD , 8'd4 , 6'd10, 32'h0       , 32'h00000058},
    '{OP_TX , 8'd2 , 6'd5 , 32'h0       , 32'h0       }, // R2 tx empty
    '{OP_RD , 8'd2 , 6'd10, 32'h0       , 32'h02000058},
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h0       },
    '{OP_WR , 8'd6 , 6'd11, 32'h00080000, 32'h0       },
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h00000020},
    '{OP_RD , 8'd6 , 6'd11, 32'h0       , 32'h00080000},
    '{OP_WR , 8'd6 , 6'd11, 32'hFFFFFFFF, 32'h0       },
    '{OP_RD , 8'd6 , 6'd11, 32'h0       , 32'h00080005},
    '{OP_OVR, 8'd2 , 6'd3 , 32'h0       , 32'h0       }, // R2 overrun
    '{OP_RD , 8'd2 , 6'd6 , 32'h0       , 32'h00002000},
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h00000028},
    '{OP_RX , 8'd2 , 6'd15, 32'h0       , 32'h0       }, // top channel
    '{OP_WR , 8'd6 , 6'd31, 32'h4       , 32'h0       },
    '{OP_RD , 8'd6 , 6'd32, 32'h0       , 32'h00008028},
    '{OP_WR , 8'd7 , 6'd33, 32'h7FFF    , 32'h0       },
    '{OP_IRQ, 8'd7 , 6'd0 , 32'h0       , 32'h1       },
    '{OP_WR , 8'd7 , 6'd33, 32'hFFFF    , 32'h0       },
    '{OP_IRQ, 8'd7 , 6'd0 , 32'h0       , 32'h0       }
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [NCH-1:0] rx_evt = '0, ovr_evt = '0, tx_evt = '0;
  logic [NCH-1:0] dcd = '0, dsr = '0, cts = '0, ri = '0;
  logic           irq_o;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sio_irq_agg dut (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rx_evt_i  (rx_evt),
    .ovr_evt_i (ovr_evt),
    .tx_evt_i  (tx_evt),
    .dcd_i     (dcd),
    .dsr_i     (dsr),
    .cts_i     (cts),
    .ri_i      (ri),
    .irq_o     (irq_o)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_modem(input int ch, input logic [3:0] v);
    @(negedge clk);
    dcd[ch] = v[0]; dsr[ch] = v[1]; cts[ch] = v[2]; ri[ch] = v[3];
    repeat (4) @(negedge clk);
  endtask

  task automatic run_table();
    logic [31:0] rd;
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR: bus_write(TBL[i].addr, TBL[i].data);
        OP_RD: begin
          bus_read(TBL[i].addr, rd);
          check(int'(TBL[i].req), $sformatf("vector %0d read", i), rd, TBL[i].exp);
        end
        OP_RX, OP_OVR, OP_TX: begin
          @(negedge clk);
          if (TBL[i].op == OP_RX)  rx_evt[TBL[i].addr]  = 1'b1;
          if (TBL[i].op == OP_OVR) ovr_evt[TBL[i].addr] = 1'b1;
          if (TBL[i].op == OP_TX)  tx_evt[TBL[i].addr]  = 1'b1;
          @(negedge clk);
          rx_evt = '0; ovr_evt = '0; tx_evt = '0;
        end
        OP_MDM: set_modem(int'(TBL[i].addr), TBL[i].data[3:0]);
        default: begin
          repeat (2) @(negedge clk);
          check(int'(TBL[i].req), $sformatf("vector %0d irq", i),
                {31'b0, irq_o}, TBL[i].exp);
        end
      endcase
    end
  endtask

  initial begin
    repeat (TIMEOUT_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    run_table();

    // R9: exact latency from event to line on ch0
    bus_write(6'd1, 32'h4);
    bus_write(6'd33, 32'hFFFE);
    repeat (2) @(negedge clk);
    check(9, "idle before pulse", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    rx_evt[0] = 1'b1;
    @(negedge clk);
    rx_evt[0] = 1'b0;
    check(9, "same edge as flag", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check(9, "one edge later", {31'b0, irq_o}, 32'h1);

    // R5: clear and event together, the flag stays
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'd0; reg_wdata = 32'h1; rx_evt[0] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; rx_evt[0] = 1'b0;
    bus_read(6'd0, rd);
    check(5, "event beats clear", rd, 32'h1);

    // R4: a clear on its own takes effect; zeros do nothing
    bus_write(6'd0, 32'h1);
    bus_read(6'd0, rd);
    check(4, "plain clear", rd, 32'h0);
    bus_write(6'd6, 32'h0);
    bus_read(6'd6, rd);
    check(4, "zero write ignored", rd, 32'h00002000);

    // R10: unmapped address reads zero
    bus_read(6'd40, rd);
    check(10, "unmapped read", rd, 32'h0);

    // R1: reset in the middle of a run
    set_modem(5, 4'h0);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(1, "line after reset", {31'b0, irq_o}, 32'h0);
    bus_read(6'd33, rd);
    check(1, "mask after reset", rd, 32'h0000FFFF);
    bus_read(6'd6, rd);
    check(1, "ch3 flags after reset", rd, 32'h0);
    bus_read(6'd11, rd);
    check(1, "ch5 control after reset", rd, 32'h0);
    bus_read(6'd35, rd);
    check(1, "card after reset", rd, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule